// File: doc/BRIEF.md
# Programmable Tick Interrupt Timer

This block produces a periodic interrupt from a slow timebase. A one-cycle enable pulse arriving at 32768 Hz drives a free-running prescaler. A four-bit rate field in the control register picks how many timebase pulses go into each counting step, always a power of two. A down counter loaded from a programmable reload value counts those steps. When it runs out, the block latches a pending flag, raises its interrupt line, and starts the next period from the reload value at once.

Software drives the block through a plain register port with a write strobe, a two-bit register select, write data and combinational read data. The tick counter starts and stops only on edges of its enable bits in the control register. It never starts from a zero reload value, and reload values that are too small are refused.

Top module: `tick_timer`

## Requirements
- R1: After reset all four registers read zero, the interrupt is low, and the current count stays zero while the timebase runs.
- R2: A write to the count register is stored only if the value is greater than 2 (MIN_CNT). Any other value leaves the stored count unchanged.
- R3: The control register reads back the value last written. Bit 0 is the master enable, bit 8 is the tick enable and bits [7:4] hold the rate select.
- R4: A control write that sets the master enable and moves the tick enable from 0 to 1 loads the counter with the stored count and starts it, provided that count is non-zero. The current count reads that value right after the write.
- R5: A tick-enable rising write while the stored count is zero does not start the counter.
- R6: While running, the counter decrements once per counting step. A step that finds the count at 1 sets status bit 0, raises tick_irq and reloads the stored count, and counting continues. Steps happen only on timebase pulses.
- R7: The prescaler issues one counting step every 2^select timebase pulses, so the interrupt period is count × 2^select pulses.
- R8: A control write that keeps the master enable set and moves the tick enable from 1 to 0 stops the counter, and the current count holds its value.
- R9: A control write that clears a set master enable stops the counter whatever the tick enable is. Setting the master enable again without a new tick-enable rising edge does not restart it.
- R10: A tick-enable rising edge written together with a clear master enable has no effect on the counter.
- R11: Writing 1 to status bit 0 clears the pending flag and drops tick_irq. Writing 0 there changes nothing. An expiry in the same cycle as the clear wins.
- R12: The register select is 0 for control, 1 for count, 2 for status and 3 for current count. Status shows the pending flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | One-cycle pulse at the 32768 Hz timebase rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the selected register (combinational) |
| tick_irq | output | 1 | Tick interrupt, high while the pending flag is set |

## Verification
The bench uses the default parameters: 16-bit data and count, a four-bit rate select, and a refusal threshold of 2. base_en is held high for most of the run, so one timebase pulse arrives every clock. This brings whole periods at rate selects 0 and 3 within a few dozen cycles. A short stretch with base_en low shows that counting stops between pulses. The 16-bit count lets the bench write the largest value, 0xFFFF, and read it back without waiting out such a long period.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic [1:0] {
      REG_CTRL    = 2'd0,
      REG_COUNT   = 2'd1,
      REG_STATUS  = 2'd2,
      REG_CURRENT = 2'd3
   } reg_sel_e;

   localparam int MASTER_BIT = 0;
   localparam int TICK_BIT   = 8;
   localparam int SEL_LSB    = 4;
   localparam int PEND_BIT   = 0;
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_en,
   input  logic [SEL_W-1:0] sel,
   output logic             cnt_en
);
   localparam int PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   // low sel bits of the free counter all ones marks the last pulse of a group
   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = (sel > SEL_W'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pre_q <= '0;
      else if (base_en)
         pre_q <= pre_q + 1'b1;
   end

   assign cnt_en = base_en && ((pre_q & mask) == mask);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
   import tick_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 16,
   parameter int SEL_W   = 4,
   parameter int MIN_CNT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [CNT_W-1:0]  reload_q,
   output logic              pending_q,
   output logic [SEL_W-1:0]  sel,
   output logic              start,
   output logic              stop
);
   localparam logic [DATA_W-1:0] MIN_V = DATA_W'(MIN_CNT);

   logic ctrl_wr, cnt_wr, stat_wr;
   logic new_m, old_m, new_t, old_t;

   assign ctrl_wr = wr_en && (addr == REG_CTRL);
   assign cnt_wr  = wr_en && (addr == REG_COUNT);
   assign stat_wr = wr_en && (addr == REG_STATUS);

   assign new_m = wdata[MASTER_BIT];
   assign old_m = ctrl_q[MASTER_BIT];
   assign new_t = wdata[TICK_BIT];
   assign old_t = ctrl_q[TICK_BIT];

   assign start = ctrl_wr && new_m && new_t && !old_t && (reload_q != '0);
   assign stop  = ctrl_wr && ((old_m && !new_m) || (new_m && old_t && !new_t));
   assign sel   = ctrl_q[SEL_LSB +: SEL_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         reload_q  <= '0;
         pending_q <= 1'b0;
      end else begin
         if (ctrl_wr)
            ctrl_q <= wdata;
         if (cnt_wr && (wdata > MIN_V))
            reload_q <= wdata[CNT_W-1:0];
         if (expire)
            pending_q <= 1'b1;
         else if (stat_wr && wdata[PEND_BIT])
            pending_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tick_down.sv
module tick_down #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             cnt_en,
   input  logic [CNT_W-1:0] reload,
   output logic             run,
   output logic [CNT_W-1:0] cur,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign expire = run && cnt_en && !start && !stop && (cur <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         cur <= '0;
      end else if (start) begin
         run <= 1'b1;
         cur <= reload;
      end else if (stop) begin
         run <= 1'b0;
      end else if (run && cnt_en) begin
         if (cur <= ONE)
            cur <= reload;
         else
            cur <= cur - ONE;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 16,
   parameter int SEL_W   = 4,
   parameter int MIN_CNT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_en,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              tick_irq
);
   if (DATA_W <= TICK_BIT) begin : g_bad_data
      $error("DATA_W must reach the tick enable bit");
   end
   if (SEL_LSB + SEL_W > TICK_BIT) begin : g_bad_sel
      $error("rate select overlaps the tick enable");
   end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must lie in 2..DATA_W");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  reload_q;
   logic [CNT_W-1:0]  cur_cnt;
   logic [SEL_W-1:0]  sel;
   logic pending_q, ld_start, ld_stop, cnt_en, run, expire;

   tick_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W), .MIN_CNT(MIN_CNT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .expire(expire), .ctrl_q(ctrl_q), .reload_q(reload_q), .pending_q(pending_q),
      .sel(sel), .start(ld_start), .stop(ld_stop)
   );

   tick_prescale #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .base_en(base_en), .sel(sel), .cnt_en(cnt_en)
   );

   tick_down #(.CNT_W(CNT_W)) u_down (
      .clk(clk), .rst_n(rst_n), .start(ld_start), .stop(ld_stop), .cnt_en(cnt_en),
      .reload(reload_q), .run(run), .cur(cur_cnt), .expire(expire)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CTRL:    rdata = ctrl_q;
         REG_COUNT:   rdata = DATA_W'(reload_q);
         REG_STATUS:  rdata[PEND_BIT] = pending_q;
         default:     rdata = DATA_W'(cur_cnt);
      endcase
   end

   assign tick_irq = pending_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
   import tick_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 16,
   parameter int MIN_CNT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic              tick_irq,
   input logic              expire,
   input logic              run,
   input logic [CNT_W-1:0]  cur,
   input logic [CNT_W-1:0]  reload,
   input logic              old_tick
);
   localparam logic [DATA_W-1:0] MIN_V = DATA_W'(MIN_CNT);

   // R2
   cnt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_COUNT && wdata <= MIN_V) |=> $stable(reload));

   // R4
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_CTRL && wdata[MASTER_BIT] && wdata[TICK_BIT] && !old_tick
       && reload != '0) |=> (run && cur == $past(reload)));

   // R5
   zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && reload == '0) |=> !run);

   // R6
   expire_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> tick_irq);

   // R9
   master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_CTRL && !wdata[MASTER_BIT]) |=> !run);

   // R11
   clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_STATUS && wdata[PEND_BIT] && !expire) |=> !tick_irq);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .tick_irq(tick_irq), .expire(expire), .run(run), .cur(cur_cnt),
   .reload(reload_q), .old_tick(ctrl_q[8])
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          base_en = 1'b1;
   logic          wr_en = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          tick_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tick_timer u_dut (
      .clk(clk), .rst_n(rst_n), .base_en(base_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .tick_irq(tick_irq)
   );

   // {written value, expected stored count afterwards}
   localparam logic [31:0] CNT_VEC [8] = '{
      {16'h0000, 16'h0000}, {16'h0001, 16'h0000}, {16'h0002, 16'h0000},
      {16'h0003, 16'h0003}, {16'h0002, 16'h0003}, {16'h0007, 16'h0007},
      {16'hFFFF, 16'hFFFF}, {16'h0001, 16'hFFFF}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual 0x0 expected 0x1");
         finish_run();
      end
   end

   initial begin
      int v;
      int k;
      idle(3);
      rst_n = 1'b1;
      idle(4);

      // R1 R12: reset state of every register
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 reset register", v, 0);
      end
      check("R1 irq after reset", int'(tick_irq), 0);

      // R5: tick rising with zero count does not start
      wr(2'd0, 16'h0101);
      rd(2'd0, v);
      check("R3 control readback", v, 16'h0101);
      idle(10);
      rd(2'd3, v);
      check("R5 no start on zero count", v, 0);
      check("R5 irq stays low", int'(tick_irq), 0);
      wr(2'd0, 16'h0001);

      // R2: count acceptance table
      for (int i = 0; i < 8; i++) begin
         wr(2'd1, CNT_VEC[i][31:16]);
         rd(2'd1, v);
         check("R2 count write filter", v, int'(CNT_VEC[i][15:0]));
      end
      wr(2'd1, 16'd5);

      // R4 R6: start, countdown, expiry and reload at select 0
      wr(2'd0, 16'h0101);
      rd(2'd3, v);
      check("R4 loaded on start", v, 5);
      for (int s = 4; s >= 1; s--) begin
         @(negedge clk);
         rd(2'd3, v);
         check("R6 countdown", v, s);
         check("R6 irq before expiry", int'(tick_irq), 0);
      end
      @(negedge clk);
      rd(2'd3, v);
      check("R6 reload on expiry", v, 5);
      check("R6 irq on expiry", int'(tick_irq), 1);
      rd(2'd2, v);
      check("R12 status pending bit", v, 1);
      base_en = 1'b0;
      idle(4);
      rd(2'd3, v);
      check("R6 no step without timebase", v, 5);
      base_en = 1'b1;

      // R8: tick enable falling stops and holds
      wr(2'd0, 16'h0001);
      idle(5);
      rd(2'd3, v);
      check("R8 held after stop", v, 5);

      // R11: write-one-to-clear
      wr(2'd2, 16'h0000);
      check("R11 zero write keeps irq", int'(tick_irq), 1);
      wr(2'd2, 16'h0001);
      check("R11 one write clears irq", int'(tick_irq), 0);
      rd(2'd2, v);
      check("R11 status cleared", v, 0);

      // R9: master falling stops; re-enable without tick edge stays stopped
      wr(2'd0, 16'h0101);
      idle(2);
      rd(2'd3, v);
      check("R9 running before master off", v, 3);
      wr(2'd0, 16'h0100);
      idle(4);
      rd(2'd3, v);
      check("R9 stopped by master off", v, 3);
      wr(2'd0, 16'h0101);
      idle(3);
      rd(2'd3, v);
      check("R9 no restart without tick edge", v, 3);

      // R10: tick rising with master clear is ignored
      wr(2'd0, 16'h0000);
      wr(2'd0, 16'h0100);
      idle(3);
      rd(2'd3, v);
      check("R10 ignored while master clear", v, 3);
      check("R10 irq low", int'(tick_irq), 0);

      // R7: select 3 gives count*8 cycles per period
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'd3);
      wr(2'd0, 16'h0031);
      wr(2'd0, 16'h0131);
      k = 0;
      while (!tick_irq && k < 200) begin
         @(negedge clk);
         k++;
      end
      check("R7 first expiry seen", int'(tick_irq), 1);
      wr(2'd2, 16'h0001);
      k = 1;
      while (!tick_irq && k < 500) begin
         @(negedge clk);
         k++;
      end
      check("R7 period at select 3", k, 24);

      // R1: reset in mid-run
      rst_n = 1'b0;
      idle(1);
      rst_n = 1'b1;
      rd(2'd0, v);
      check("R1 control cleared", v, 0);
      check("R1 irq cleared", int'(tick_irq), 0);
      idle(10);
      rd(2'd3, v);
      check("R1 counter stopped", v, 0);

      done = 1;
      finish_run();
   end
endmodule